// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block is one logic cell of a small programmable logic array. A programmable AND plane forms a handful of product terms over a set of routed global signals and a pool of block-wide shared expander terms, taking each input as its true form, its complement or ignoring it. A fixed OR gate sums the terms that the cell keeps. A polarity XOR follows the sum, and then either a configurable flip-flop or a bypass path drives the cell output.

Terms the cell does not keep can be lent to the next cell as a parallel expander. A cell can also OR in the terms lent to it by its neighbour and pass them further down the chain. Each lent bundle travels with a count of the product terms it carries, so that no single sum ever grows beyond `MAX_TERMS` terms. The flip-flop takes its clock, clock enable, clear and preset each from a source picked by configuration. Its value while power-on reset is held is also set by configuration. All configuration is held static by the surrounding array. The data path is pure logic plus one flip-flop and has no flow control, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `sop_macrocell`

## Requirements
- R1: Each product term takes 2 configuration bits per literal at `and_cfg_i[(t*N_LIT+l)*2 +: 2]`: 00 ignores the literal, 01 needs it high, 10 needs it low, and 11 forces the term to 0. A term with every literal at 00 is 1. Literal indices 0..N_GIN-1 are `gin_i`.
- R2: Literal indices N_GIN..N_GIN+N_SHR-1 are the shared expander inputs `shx_i`, and they are used in the AND plane exactly like the global inputs.
- R3: Term t is routed by `route_cfg_i[2t+1:2t]`. 00 puts it in the cell's own sum. 01 lends it to the neighbour: it is ORed into `pexp_o` and counted in `pexp_cnt_o`. 10 (control only) and 11 (off) keep it out of both.
- R4: When `use` (ctl bit 1) is set and `pexp_cnt_i` plus the number of own-sum terms is at most MAX_TERMS, `pexp_i` is ORed into the sum. Otherwise `pexp_i` has no effect on the sum.
- R5: When `fwd` (ctl bit 0) is set and `pexp_cnt_i` plus the number of lent terms is at most MAX_TERMS, `pexp_i` joins `pexp_o` and `pexp_cnt_o` = lent + `pexp_cnt_i`. Otherwise `pexp_cnt_o` counts the lent terms only. `pexp_cnt_o` never exceeds MAX_TERMS.
- R6: The data bit is the sum XOR `inv` (ctl bit 9). With `bypass` (ctl bit 10) set, `out_o` follows the data bit combinationally. With `bypass` clear, `out_o` is the flip-flop.
- R7: `clk_sel` (ctl bits 8:7) picks the register clock: 0 is `gclk0_i`, 1 is `gclk1_i`, 2 or 3 is product term 0. `clk_inv` (ctl bit 6) inverts the chosen clock. The register loads on a rising edge of the result.
- R8: With `ena_sel` (ctl bit 5) clear, every clock edge loads. With it set, an edge loads only when product term 1 is high, and the register holds otherwise.
- R9: `clr_sel` (ctl bits 4:3) picks an asynchronous clear: 0 none, 1 `gclr_i`, 2 term 2, 3 either. Clear forces the register to 0 and overrides preset.
- R10: With `pre_sel` (ctl bit 2) set, product term 3 asynchronously sets the register to 1 whenever no clear is active, and clock loads have no effect while it is held.
- R11: While `por_n_i` is low, the register holds `init` (ctl bit 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk0_i | input | 1 | Global clock 0 |
| gclk1_i | input | 1 | Global clock 1 |
| gclr_i | input | 1 | Global clear, active high |
| por_n_i | input | 1 | Power-on reset, active low |
| gin_i | input | N_GIN | Routed global signals |
| shx_i | input | N_SHR | Shared expander terms of the block |
| pexp_i | input | 1 | Parallel expander terms lent by the neighbour |
| pexp_cnt_i | input | CW | Number of terms carried on pexp_i |
| and_cfg_i | input | N_PT*N_LIT*2 | AND-plane literal codes |
| route_cfg_i | input | 2*N_PT | Per-term routing |
| ctl_cfg_i | input | 12 | Register, polarity and chaining controls |
| out_o | output | 1 | Cell result |
| pexp_o | output | 1 | Terms lent to the next cell |
| pexp_cnt_o | output | CW | Number of terms carried on pexp_o |

## Verification
The hardest cases to reach are the register's source choices. A clock edge made from a product term or from the second global clock must be produced without a stray edge when the selection changes. The stimulus therefore changes `clk_sel` only while the old and the new source are at the same level. It then makes the edge on its own by toggling `gclk1_i` or the literal behind term 0. The 32-term limit is probed at exactly MAX_TERMS and at one past it, both for absorbing and for forwarding the neighbour's terms.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    RT_OWN  = 2'b00,
    RT_LEND = 2'b01,
    RT_CTRL = 2'b10,
    RT_OFF  = 2'b11
  } smc_route_e;

  typedef struct packed {
    logic       init;
    logic       bypass;
    logic       inv;
    logic [1:0] clk_sel;
    logic       clk_inv;
    logic       ena_sel;
    logic [1:0] clr_sel;
    logic       pre_sel;
    logic       use_in;
    logic       fwd;
  } smc_ctl_t;

  localparam int CTL_W = $bits(smc_ctl_t);

  // Fixed control taps among the local terms
  localparam int TAP_CLK = 0;
  localparam int TAP_ENA = 1;
  localparam int TAP_CLR = 2;
  localparam int TAP_PRE = 3;
endpackage

// File: rtl/smc_and_plane.sv
module smc_and_plane #(
  parameter int N_LIT = 12,
  parameter int N_PT  = 5
) (
  input  logic [N_LIT-1:0]        lit_i,
  input  logic [N_PT*N_LIT*2-1:0] cfg_i,
  output logic [N_PT-1:0]         term_o
);
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] hit;
    for (genvar l = 0; l < N_LIT; l++) begin : g_lit
      logic [1:0] code;
      assign code = cfg_i[(t*N_LIT+l)*2 +: 2];
      assign hit[l] = (code == 2'b00) |
                      ((code == 2'b01) &  lit_i[l]) |
                      ((code == 2'b10) & ~lit_i[l]);
    end
    assign term_o[t] = &hit;
  end
endmodule

// File: rtl/smc_expander.sv
module smc_expander #(
  parameter int N_PT      = 5,
  parameter int MAX_TERMS = 32,
  localparam int CW       = $clog2(MAX_TERMS + 1)
) (
  input  logic [N_PT-1:0]   term_i,
  input  logic [2*N_PT-1:0] route_i,
  input  logic              use_i,
  input  logic              fwd_i,
  input  logic              pexp_i,
  input  logic [CW-1:0]     pexp_cnt_i,
  output logic              sum_o,
  output logic              pexp_o,
  output logic [CW-1:0]     pexp_cnt_o
);
  import smc_pkg::*;

  logic [N_PT-1:0] own_m, lend_m;
  logic [CW-1:0]   own_cnt, lend_cnt;
  logic [CW:0]     in_tot, fw_tot;
  logic            take_in, fwd_ok;

  for (genvar t = 0; t < N_PT; t++) begin : g_route
    assign own_m[t]  = (route_i[2*t +: 2] == RT_OWN);
    assign lend_m[t] = (route_i[2*t +: 2] == RT_LEND);
  end

  assign own_cnt  = CW'($countones(own_m));
  assign lend_cnt = CW'($countones(lend_m));

  assign in_tot  = {1'b0, pexp_cnt_i} + {1'b0, own_cnt};
  assign fw_tot  = {1'b0, pexp_cnt_i} + {1'b0, lend_cnt};
  assign take_in = use_i & (in_tot <= (CW+1)'(MAX_TERMS));
  assign fwd_ok  = fwd_i & (fw_tot <= (CW+1)'(MAX_TERMS));

  assign sum_o      = (|(term_i & own_m)) | (take_in & pexp_i);
  assign pexp_o     = (|(term_i & lend_m)) | (fwd_ok & pexp_i);
  assign pexp_cnt_o = fwd_ok ? fw_tot[CW-1:0] : lend_cnt;
endmodule

// File: rtl/smc_register.sv
module smc_register (
  input  logic clk_i,
  input  logic ena_i,
  input  logic clr_i,
  input  logic pre_i,
  input  logic por_n_i,
  input  logic init_i,
  input  logic d_i,
  output logic q_o
);
  logic force0, force1;

  assign force0 = (~por_n_i & ~init_i) | (por_n_i & clr_i);
  assign force1 = (~por_n_i &  init_i) | (por_n_i & pre_i & ~clr_i);

  always_ff @(posedge clk_i or posedge force0 or posedge force1) begin
    if (force0)      q_o <= 1'b0;
    else if (force1) q_o <= 1'b1;
    else if (ena_i)  q_o <= d_i;
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
  parameter int N_GIN     = 8,
  parameter int N_SHR     = 4,
  parameter int N_PT      = 5,
  parameter int MAX_TERMS = 32,
  localparam int N_LIT    = N_GIN + N_SHR,
  localparam int CW       = $clog2(MAX_TERMS + 1),
  localparam int AND_W    = N_PT * N_LIT * 2
) (
  input  logic                     gclk0_i,
  input  logic                     gclk1_i,
  input  logic                     gclr_i,
  input  logic                     por_n_i,
  input  logic [N_GIN-1:0]         gin_i,
  input  logic [N_SHR-1:0]         shx_i,
  input  logic                     pexp_i,
  input  logic [CW-1:0]            pexp_cnt_i,
  input  logic [AND_W-1:0]         and_cfg_i,
  input  logic [2*N_PT-1:0]        route_cfg_i,
  input  logic [smc_pkg::CTL_W-1:0] ctl_cfg_i,
  output logic                     out_o,
  output logic                     pexp_o,
  output logic [CW-1:0]            pexp_cnt_o
);
  import smc_pkg::*;

  smc_ctl_t        ctl;
  logic [N_PT-1:0] term;
  logic            sum, d;
  logic            clk_src, reg_clk, reg_ena, reg_clr, reg_pre, q;

  assign ctl = smc_ctl_t'(ctl_cfg_i);

  smc_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_plane (
    .lit_i  ({shx_i, gin_i}),
    .cfg_i  (and_cfg_i),
    .term_o (term)
  );

  smc_expander #(.N_PT(N_PT), .MAX_TERMS(MAX_TERMS)) u_exp (
    .term_i     (term),
    .route_i    (route_cfg_i),
    .use_i      (ctl.use_in),
    .fwd_i      (ctl.fwd),
    .pexp_i     (pexp_i),
    .pexp_cnt_i (pexp_cnt_i),
    .sum_o      (sum),
    .pexp_o     (pexp_o),
    .pexp_cnt_o (pexp_cnt_o)
  );

  assign d = sum ^ ctl.inv;

  always_comb begin
    unique case (ctl.clk_sel)
      2'd0:    clk_src = gclk0_i;
      2'd1:    clk_src = gclk1_i;
      default: clk_src = term[TAP_CLK];
    endcase
  end

  assign reg_clk = clk_src ^ ctl.clk_inv;
  assign reg_ena = ~ctl.ena_sel | term[TAP_ENA];
  assign reg_clr = (ctl.clr_sel[0] & gclr_i) | (ctl.clr_sel[1] & term[TAP_CLR]);
  assign reg_pre = ctl.pre_sel & term[TAP_PRE];

  smc_register u_reg (
    .clk_i   (reg_clk),
    .ena_i   (reg_ena),
    .clr_i   (reg_clr),
    .pre_i   (reg_pre),
    .por_n_i (por_n_i),
    .init_i  (ctl.init),
    .d_i     (d),
    .q_o     (q)
  );

  assign out_o = ctl.bypass ? d : q;
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int MAX_TERMS = 32,
  parameter int CW        = 6
) (
  input logic          gclk0_i,
  input logic          por_n_i,
  input logic          bypass,
  input logic [1:0]    clk_sel,
  input logic          clk_inv,
  input logic          reg_ena,
  input logic          reg_clr,
  input logic          reg_pre,
  input logic          q,
  input logic          d,
  input logic          out_o,
  input logic [CW-1:0] pexp_cnt_o
);
  // R5: outgoing count stays within the term budget
  a_r5_cnt_bound: assert property (@(posedge gclk0_i) disable iff (!por_n_i)
    pexp_cnt_o <= CW'(MAX_TERMS));

  // R6: bypass hands the data bit straight to the output
  a_r6_bypass: assert property (@(posedge gclk0_i) disable iff (!por_n_i)
    bypass |-> (out_o == d));

  // R8: a disabled edge on the plain global clock leaves the register alone
  a_r8_hold: assert property (@(posedge gclk0_i) disable iff (!por_n_i)
    ($past(!reg_ena && clk_sel == 2'd0 && !clk_inv && !reg_clr && !reg_pre)
     && clk_sel == 2'd0 && !clk_inv && !reg_clr && !reg_pre) |-> (q == $past(q)));

  // R9: an active clear holds the register at zero
  a_r9_clear_wins: assert property (@(posedge gclk0_i) disable iff (!por_n_i)
    reg_clr |-> (q == 1'b0));

  // R10: preset without clear holds the register at one
  a_r10_preset: assert property (@(posedge gclk0_i) disable iff (!por_n_i)
    (reg_pre && !reg_clr) |-> (q == 1'b1));
endmodule

bind sop_macrocell smc_checker #(.MAX_TERMS(MAX_TERMS), .CW(CW)) u_chk (
  .gclk0_i    (gclk0_i),
  .por_n_i    (por_n_i),
  .bypass     (ctl.bypass),
  .clk_sel    (ctl.clk_sel),
  .clk_inv    (ctl.clk_inv),
  .reg_ena    (reg_ena),
  .reg_clr    (reg_clr),
  .reg_pre    (reg_pre),
  .q          (q),
  .d          (d),
  .out_o      (out_o),
  .pexp_cnt_o (pexp_cnt_o)
);

// File: tb/test_sop_macrocell.sv
module test_sop_macrocell;
  import smc_pkg::*;

  localparam int N_GIN = 8, N_SHR = 4, N_PT = 5, MAXT = 32;
  localparam int N_LIT = N_GIN + N_SHR;
  localparam int CW = $clog2(MAXT + 1);
  localparam int AND_W = N_PT * N_LIT * 2;

  logic gclk0 = 1'b0, gclk1 = 1'b0, gclr = 1'b0, por_n = 1'b1;
  logic [N_GIN-1:0] gin = '0;
  logic [N_SHR-1:0] shx = '0;
  logic pexp_in = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic [AND_W-1:0] and_cfg;
  logic [2*N_PT-1:0] route;
  smc_ctl_t ctl;
  logic out, pexp_out;
  logic [CW-1:0] cnt_out;

  always #4 gclk0 = ~gclk0;

  sop_macrocell #(.N_GIN(N_GIN), .N_SHR(N_SHR), .N_PT(N_PT), .MAX_TERMS(MAXT)) i_sop_macrocell (
    .gclk0_i(gclk0), .gclk1_i(gclk1), .gclr_i(gclr), .por_n_i(por_n),
    .gin_i(gin), .shx_i(shx), .pexp_i(pexp_in), .pexp_cnt_i(cnt_in),
    .and_cfg_i(and_cfg), .route_cfg_i(route), .ctl_cfg_i(ctl),
    .out_o(out), .pexp_o(pexp_out), .pexp_cnt_o(cnt_out)
  );

  typedef struct {
    logic          o;
    logic          p;
    logic [CW-1:0] c;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic setlit(input int t, input int l, input logic [1:0] c);
    and_cfg[(t*N_LIT+l)*2 +: 2] = c;
  endtask

  task automatic setroute(input int t, input logic [1:0] c);
    route[2*t +: 2] = c;
  endtask

  task automatic kill_all();
    and_cfg = '0;
    for (int t = 0; t < N_PT; t++) setlit(t, 0, 2'b11);
    route = '1;
  endtask

  task automatic settle();
    @(negedge gclk0);
  endtask

  // driver: queue the expected item, then let the monitor compare
  task automatic chk(input logic eo, input logic ep, input int ec, input string r);
    exp_t e;
    #2;
    e.o = eo; e.p = ep; e.c = CW'(ec); e.req = r;
    sb_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (out !== e.o || pexp_out !== e.p || cnt_out !== e.c) begin
          n_bad++;
          $display("FAIL %s: got out=%b pexp=%b cnt=%0d, expected out=%b pexp=%b cnt=%0d",
                   e.req, out, pexp_out, cnt_out, e.o, e.p, e.c);
        end
      end
    end
  end

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_up();
    end
  end

  initial begin
    kill_all();
    ctl = '0;
    #1 por_n = 1'b0;
    settle();
    chk(0, 0, 0, "R11 reset init=0");
    ctl.init = 1'b1;
    chk(1, 0, 0, "R11 reset init=1");
    settle();
    por_n = 1'b1;
    chk(1, 0, 0, "R11 after release");

    // combinational path
    ctl.bypass = 1'b1;
    settle();
    setlit(0, 0, 2'b01); setlit(0, 1, 2'b10); setroute(0, RT_OWN);
    gin = 8'h01; chk(1, 0, 0, "R1 true/compl match");
    gin = 8'h03; chk(0, 0, 0, "R1 complement fails");
    gin = 8'h00; chk(0, 0, 0, "R1 true fails");
    setlit(0, 0, 2'b00); setlit(0, 1, 2'b00);
    chk(1, 0, 0, "R1 all ignored");
    setlit(0, 0, 2'b11);
    chk(0, 0, 0, "R1 code 11 kills");

    setlit(0, 0, 2'b00); setlit(0, N_GIN, 2'b01);
    shx = 4'h0; chk(0, 0, 0, "R2 shared low");
    shx = 4'h1; chk(1, 0, 0, "R2 shared high");
    setlit(0, N_GIN+1, 2'b10);
    shx = 4'h3; chk(0, 0, 0, "R2 shared complement");
    shx = 4'h1; chk(1, 0, 0, "R2 shared pair");
    shx = 4'h0;

    kill_all();
    setlit(0, 0, 2'b01); gin = 8'h01;
    setroute(0, RT_LEND); chk(0, 1, 1, "R3 lend");
    setroute(0, RT_CTRL); chk(0, 0, 0, "R3 control only");
    setroute(0, RT_OFF);  chk(0, 0, 0, "R3 off");
    setroute(0, RT_LEND); setlit(1, 0, 2'b01); setroute(1, RT_LEND);
    chk(0, 1, 2, "R3 two lent");

    kill_all();
    setlit(0, 0, 2'b01); setlit(1, 0, 2'b01);
    setroute(0, RT_OWN); setroute(1, RT_OWN); gin = 8'h00;
    ctl.use_in = 1'b1; pexp_in = 1'b1;
    cnt_in = 30; chk(1, 0, 0, "R4 absorb at limit");
    cnt_in = 31; chk(0, 0, 0, "R4 over limit ignored");
    ctl.use_in = 1'b0; cnt_in = 5; chk(0, 0, 0, "R4 use off ignored");

    setroute(1, RT_OFF); setroute(0, RT_LEND); ctl.fwd = 1'b1;
    cnt_in = 31; chk(0, 1, 32, "R5 forward at limit");
    cnt_in = 32; chk(0, 0, 1, "R5 forward over limit");
    ctl.fwd = 1'b0; cnt_in = 3; chk(0, 0, 1, "R5 forward off");
    pexp_in = 1'b0; cnt_in = 0;

    setroute(0, RT_OWN); gin = 8'h01;
    chk(1, 0, 0, "R6 polarity plain");
    ctl.inv = 1'b1; chk(0, 0, 0, "R6 polarity inverted");
    gin = 8'h00; chk(1, 0, 0, "R6 inverted zero");
    ctl.inv = 1'b0;

    // registered path: term4=gin7 data, term0..3 = gin6..gin3 controls
    settle();
    and_cfg = '0;
    setlit(4, 7, 2'b01); setroute(4, RT_OWN);
    setlit(0, 6, 2'b01); setroute(0, RT_CTRL);
    setlit(1, 5, 2'b01); setroute(1, RT_CTRL);
    setlit(2, 4, 2'b01); setroute(2, RT_CTRL);
    setlit(3, 3, 2'b01); setroute(3, RT_CTRL);
    gin = 8'h00; ctl.bypass = 1'b0;
    settle(); chk(0, 0, 0, "R7 gclk0 loads 0");
    gin = 8'h80; settle(); chk(1, 0, 0, "R7 gclk0 loads 1");
    ctl.ena_sel = 1'b1; gin = 8'h00; settle(); chk(1, 0, 0, "R8 hold when term1 low");
    gin = 8'h20; settle(); chk(0, 0, 0, "R8 load when term1 high");
    ctl.ena_sel = 1'b0;

    ctl.clk_sel = 2'd1; gin = 8'h80; settle(); chk(0, 0, 0, "R7 gclk1 idle");
    gclk1 = 1'b1; chk(1, 0, 0, "R7 gclk1 edge");
    settle(); gclk1 = 1'b0;
    ctl.clk_sel = 2'd2; gin = 8'h00; settle(); chk(1, 0, 0, "R7 term0 idle");
    gin = 8'h40; chk(0, 0, 0, "R7 term0 edge");

    settle();
    ctl.clk_sel = 2'd1; ctl.clk_inv = 1'b1; gin = 8'h80;
    chk(0, 0, 0, "R7 inverted no switch edge");
    settle(); gclk1 = 1'b1; chk(0, 0, 0, "R7 inverted falling");
    settle(); gclk1 = 1'b0; chk(1, 0, 0, "R7 inverted rising");

    settle();
    ctl.clk_sel = 2'd0; ctl.clk_inv = 1'b0;
    ctl.clr_sel = 2'd1; gclr = 1'b1; chk(0, 0, 0, "R9 global clear");
    ctl.pre_sel = 1'b1; gin = 8'h08; chk(0, 0, 0, "R9 clear beats preset");
    gclr = 1'b0; chk(1, 0, 0, "R10 preset async");
    settle(); chk(1, 0, 0, "R10 preset blocks load");
    ctl.clr_sel = 2'd2; gin = 8'h18; chk(0, 0, 0, "R9 term2 clear");
    ctl.clr_sel = 2'd0; ctl.pre_sel = 1'b0; gin = 8'h00;
    settle(); chk(0, 0, 0, "R9 released");

    done = 1;
    finish_up();
  end
endmodule